// File: doc/BRIEF.md
# SDRAM Mode Register Load Controller

This block keeps the mode word of a DDR2-style memory device and rewrites it whenever a legal load-mode command arrives on the command/address bus. It sits next to a memory controller's command issue stage. It watches a command strobe with its decoded command kind, the bank-address bits and the fourteen address bits that carry the new mode word. It also sees two status flags from the scheduler: one says every bank is precharged, the other says a read or write burst is still running.

A load is taken only when all of these hold: the bank-address bits select this register, the banks are idle, no burst is running, the burst-length code is one the device supports, and the post-load settle window has expired. An accepted load replaces every field at once. The DLL-reset bit reads back high for a single cycle and then clears itself. After an accepted load the ready output stays low for a programmable settle time. Any command offered while ready is low is refused and flagged. A load that breaks a legality rule is also flagged and leaves the stored word as it was.

Top module: `sdram_mr_ctrl`

## Requirements
- R1: After reset, burst_len_code is 3'b010 (four beats), every other field output is 0, cmd_ready is 1 and cmd_error is 0.
- R2: A load-mode command is cmd_valid with cmd_kind 3'b000 and bank_sel 2'b00. It is accepted when cmd_ready is 1, banks_idle is 1, burst_busy is 0 and the burst-length code is legal. At the next clock edge all fields are replaced from mode_bits with this layout: [2:0] burst length code, [3] interleaved order, [6:4] CAS latency code, [7] test mode, [8] DLL reset, [11:9] write recovery code, [12] slow power-down exit, [13] reserved bit.
- R3: A load-mode command with bank_sel other than 2'b00, offered while cmd_ready is 1, changes no field and raises no error.
- R4: A load-mode command to bank_sel 2'b00, offered while banks_idle is 0 or burst_busy is 1, sets cmd_error in the next cycle and changes no field.
- R5: A load whose mode_bits[2:0] is neither 3'b010 nor 3'b011 sets cmd_error in the next cycle and changes no field, so the burst length code is always one of the two legal codes.
- R6: dll_reset is 1 for exactly one cycle after an accepted load with mode_bits[8] set, then returns to 0 by itself.
- R7: After a load accepted at clock edge k, cmd_ready is 0 after edges k through k+TMRD-2. The earliest edge at which another command is taken is k+TMRD (TMRD defaults to 2).
- R8: Any command (cmd_valid 1, any cmd_kind) offered while cmd_ready is 0 sets cmd_error in the next cycle and has no effect on the fields or on the settle timer.
- R9: A command whose cmd_kind is not 3'b000, offered while cmd_ready is 1, changes no field and raises no error.
- R10: cmd_error is a one-cycle flag and is 0 in any cycle that does not follow a refused command.
- R11: Apart from the self-clearing DLL-reset bit, every field keeps its value in every cycle that does not follow an accepted load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_kind | input | 3 | Decoded command kind; 3'b000 is load-mode |
| bank_sel | input | 2 | Bank-address bits of the command |
| mode_bits | input | 14 | Address bits carrying the new mode word |
| banks_idle | input | 1 | All banks are precharged |
| burst_busy | input | 1 | A read or write burst is in progress |
| burst_len_code | output | 3 | Stored burst length code (3'b010 = 4, 3'b011 = 8) |
| burst_interleave | output | 1 | Stored burst order (1 = interleaved) |
| cas_latency | output | 3 | Stored CAS latency code |
| test_mode | output | 1 | Stored test-mode bit |
| dll_reset | output | 1 | Self-clearing DLL-reset bit |
| write_recovery | output | 3 | Stored write recovery code |
| pd_slow_exit | output | 1 | Stored power-down exit mode |
| mode_rsvd | output | 1 | Stored reserved bit |
| cmd_ready | output | 1 | The next command may be issued |
| cmd_error | output | 1 | The previous cycle's command was refused |

## Verification
On every cycle the assertions check that the fields hold between accepted loads, that the DLL-reset bit never stays high for two cycles, that a command offered during the settle window is always flagged, that the error flag never appears without a command, that the burst code stays legal, and that ready drops right after an accepted load. Only the bench scenarios can show that each field lands at its own bit position, and that loads to other banks or non-load commands leave the word untouched. They also show that the earliest legal follow-up command, TMRD edges after a load, is actually taken and not merely unflagged.

// File: rtl/sdram_mr_pkg.sv
package sdram_mr_pkg;

  localparam int MR_W = 14;

  localparam logic [2:0] CMD_LOAD_MODE = 3'b000;
  localparam logic [2:0] BL_CODE_FOUR  = 3'b010;
  localparam logic [2:0] BL_CODE_EIGHT = 3'b011;

  // Packed from MSB to LSB so that a cast of the raw word lands each field
  // on its bit position.
  typedef struct packed {
    logic       rsvd;
    logic       pd_slow;
    logic [2:0] wr;
    logic       dll;
    logic       tm;
    logic [2:0] cl;
    logic       bt;
    logic [2:0] bl;
  } mr_fields_t;

  function automatic logic bl_code_ok(input logic [2:0] code);
    return (code == BL_CODE_FOUR) || (code == BL_CODE_EIGHT);
  endfunction

  function automatic mr_fields_t unpack_mr(input logic [MR_W-1:0] word);
    return mr_fields_t'(word);
  endfunction

  function automatic mr_fields_t reset_mr();
    mr_fields_t f;
    f    = '0;
    f.bl = BL_CODE_FOUR;
    return f;
  endfunction

endpackage

// File: rtl/sdram_mr_guard.sv
module sdram_mr_guard
  import sdram_mr_pkg::*;
#(
  parameter int CMD_W  = 3,
  parameter int BANK_W = 2
) (
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_kind,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic [2:0]        bl_code,
  input  logic              banks_idle,
  input  logic              burst_busy,
  input  logic              ready,
  output logic              accept,
  output logic              refuse
);

  logic is_load;
  logic for_us;
  logic state_ok;
  logic code_ok;

  always_comb begin
    is_load  = (cmd_kind == CMD_W'(CMD_LOAD_MODE));
    for_us   = is_load && (bank_sel == '0);
    state_ok = banks_idle && !burst_busy;
    code_ok  = bl_code_ok(bl_code);
    accept   = cmd_valid && ready && for_us && state_ok && code_ok;
    refuse   = cmd_valid && (!ready || (for_us && !(state_ok && code_ok)));
  end

endmodule

// File: rtl/sdram_mr_settle.sv
module sdram_mr_settle #(
  parameter int TMRD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic ready
);

  localparam int CW = (TMRD > 1) ? $clog2(TMRD) : 1;
  localparam logic [CW-1:0] LOAD_VAL = CW'(TMRD - 1);

  logic [CW-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            left_q <= '0;
    else if (start)        left_q <= LOAD_VAL;
    else if (left_q != '0) left_q <= left_q - 1'b1;
  end

  assign ready = (left_q == '0);

endmodule

// File: rtl/sdram_mr_store.sv
module sdram_mr_store
  import sdram_mr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [MR_W-1:0] word,
  output mr_fields_t      fields
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    fields     <= reset_mr();
    else if (load) fields     <= unpack_mr(word);
    else           fields.dll <= 1'b0;
  end

endmodule

// File: rtl/sdram_mr_ctrl.sv
module sdram_mr_ctrl
  import sdram_mr_pkg::*;
#(
  parameter int TMRD   = 2,
  parameter int CMD_W  = 3,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_kind,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic [MR_W-1:0]   mode_bits,
  input  logic              banks_idle,
  input  logic              burst_busy,
  output logic [2:0]        burst_len_code,
  output logic              burst_interleave,
  output logic [2:0]        cas_latency,
  output logic              test_mode,
  output logic              dll_reset,
  output logic [2:0]        write_recovery,
  output logic              pd_slow_exit,
  output logic              mode_rsvd,
  output logic              cmd_ready,
  output logic              cmd_error
);

  logic       accept_w;
  logic       refuse_w;
  logic       ready_w;
  mr_fields_t fields_w;
  logic       err_q;

  sdram_mr_guard #(.CMD_W(CMD_W), .BANK_W(BANK_W)) guard_i (
    .cmd_valid  (cmd_valid),
    .cmd_kind   (cmd_kind),
    .bank_sel   (bank_sel),
    .bl_code    (mode_bits[2:0]),
    .banks_idle (banks_idle),
    .burst_busy (burst_busy),
    .ready      (ready_w),
    .accept     (accept_w),
    .refuse     (refuse_w)
  );

  sdram_mr_settle #(.TMRD(TMRD)) settle_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (accept_w),
    .ready (ready_w)
  );

  sdram_mr_store store_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept_w),
    .word   (mode_bits),
    .fields (fields_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= refuse_w;
  end

  assign burst_len_code   = fields_w.bl;
  assign burst_interleave = fields_w.bt;
  assign cas_latency      = fields_w.cl;
  assign test_mode        = fields_w.tm;
  assign dll_reset        = fields_w.dll;
  assign write_recovery   = fields_w.wr;
  assign pd_slow_exit     = fields_w.pd_slow;
  assign mode_rsvd        = fields_w.rsvd;
  assign cmd_ready        = ready_w;
  assign cmd_error        = err_q;

endmodule

// File: rtl/sdram_mr_ctrl_chk.sv
module sdram_mr_ctrl_chk
  import sdram_mr_pkg::*;
#(
  parameter int TMRD = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       accept_w,
  input mr_fields_t fields_w,
  input logic       cmd_ready,
  input logic       cmd_error
);

  logic [MR_W-2:0] held_view;
  assign held_view = {fields_w.rsvd, fields_w.pd_slow, fields_w.wr,
                      fields_w.tm, fields_w.cl, fields_w.bt, fields_w.bl};

  assert_hold_between_loads_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_w |=> $stable(held_view));

  assert_dll_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fields_w.dll |=> !fields_w.dll);

  assert_busy_window_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> cmd_error);

  assert_error_needs_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !cmd_error);

  assert_settle_starts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((TMRD > 1) && accept_w) |=> !cmd_ready);

  assert_bl_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bl_code_ok(fields_w.bl));

endmodule

bind sdram_mr_ctrl sdram_mr_ctrl_chk #(.TMRD(TMRD)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .accept_w  (accept_w),
  .fields_w  (fields_w),
  .cmd_ready (cmd_ready),
  .cmd_error (cmd_error)
);

// File: tb/sdram_mr_ctrl_tb_top.sv
module sdram_mr_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TMRD       = 2;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic [2:0]  cmd_kind;
  logic [1:0]  bank_sel;
  logic [13:0] mode_bits;
  logic        banks_idle;
  logic        burst_busy;
  logic [2:0]  burst_len_code;
  logic        burst_interleave;
  logic [2:0]  cas_latency;
  logic        test_mode;
  logic        dll_reset;
  logic [2:0]  write_recovery;
  logic        pd_slow_exit;
  logic        mode_rsvd;
  logic        cmd_ready;
  logic        cmd_error;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_mr_ctrl #(.TMRD(TMRD)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
    .bank_sel(bank_sel), .mode_bits(mode_bits), .banks_idle(banks_idle),
    .burst_busy(burst_busy), .burst_len_code(burst_len_code),
    .burst_interleave(burst_interleave), .cas_latency(cas_latency),
    .test_mode(test_mode), .dll_reset(dll_reset),
    .write_recovery(write_recovery), .pd_slow_exit(pd_slow_exit),
    .mode_rsvd(mode_rsvd), .cmd_ready(cmd_ready), .cmd_error(cmd_error)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  kind;
    logic [1:0]  bank;
    logic [13:0] bits;
    logic        idle;
    logic        busy;
    logic        exp_err;
    logic        exp_upd;
  } vec_t;

  localparam int NV = 9;
  // bits grouped as rsvd_pd_wr_dll_tm_cl_bt_bl
  localparam vec_t VEC [NV] = '{
    '{4'd2, 3'b000, 2'b00, 14'b0_0_001_1_0_011_1_011, 1'b1, 1'b0, 1'b0, 1'b1},
    '{4'd3, 3'b000, 2'b01, 14'b1_1_110_1_1_110_0_010, 1'b1, 1'b0, 1'b0, 1'b0},
    '{4'd4, 3'b000, 2'b00, 14'b1_0_100_0_1_010_0_010, 1'b0, 1'b0, 1'b1, 1'b0},
    '{4'd4, 3'b000, 2'b00, 14'b0_1_011_0_0_101_1_011, 1'b1, 1'b1, 1'b1, 1'b0},
    '{4'd5, 3'b000, 2'b00, 14'b0_1_010_0_0_010_0_101, 1'b1, 1'b0, 1'b1, 1'b0},
    '{4'd5, 3'b000, 2'b00, 14'b0_0_000_1_0_100_0_000, 1'b1, 1'b0, 1'b1, 1'b0},
    '{4'd2, 3'b000, 2'b00, 14'b1_1_101_0_1_101_0_010, 1'b1, 1'b0, 1'b0, 1'b1},
    '{4'd9, 3'b011, 2'b00, 14'b0_0_111_1_0_111_1_011, 1'b1, 1'b0, 1'b0, 1'b0},
    '{4'd2, 3'b000, 2'b00, 14'b0_0_010_0_0_100_1_011, 1'b1, 1'b0, 1'b0, 1'b1}
  };

  function automatic string req_name(input logic [3:0] id);
    case (id)
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [13:0] seen_word();
    return {mode_rsvd, pd_slow_exit, write_recovery, dll_reset, test_mode,
            cas_latency, burst_interleave, burst_len_code};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Caller stands at a falling edge; returns at the falling edge after the
  // rising edge that sampled the command.
  task automatic send(input logic [2:0] kind, input logic [1:0] bank,
                      input logic [13:0] bits, input logic idle, input logic busy);
    cmd_valid  = 1'b1;
    cmd_kind   = kind;
    bank_sel   = bank;
    mode_bits  = bits;
    banks_idle = idle;
    burst_busy = busy;
    @(negedge clk);
    cmd_valid  = 1'b0;
    banks_idle = 1'b1;
    burst_busy = 1'b0;
  endtask

  logic [13:0] model;
  logic [13:0] want;

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_kind = 3'b111; bank_sel = 2'b00;
    mode_bits = '0; banks_idle = 1'b1; burst_busy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    model = 14'b0_0_000_0_0_000_0_010;
    check("R1 fields", seen_word(), model);
    check("R1 ready", cmd_ready, 1);
    check("R1 error", cmd_error, 0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      send(VEC[i].kind, VEC[i].bank, VEC[i].bits, VEC[i].idle, VEC[i].busy);
      check(req_name(VEC[i].req), cmd_error, VEC[i].exp_err);
      if (VEC[i].exp_upd) model = VEC[i].bits;
      want    = model;
      want[8] = VEC[i].exp_upd ? VEC[i].bits[8] : 1'b0;
      check(req_name(VEC[i].req), seen_word(), want);
      repeat (TMRD) @(negedge clk);
      want    = model;
      want[8] = 1'b0;
      check("R6/R11 after settle", seen_word(), want);
      check("R10 error cleared", cmd_error, 0);
      check("R7 ready back", cmd_ready, 1);
    end

    // R8: non-load command inside the settle window
    send(3'b000, 2'b00, 14'b0_0_011_1_0_010_0_011, 1'b1, 1'b0);
    model = 14'b0_0_011_0_0_010_0_011;
    check("R6 dll high once", dll_reset, 1);
    send(3'b011, 2'b00, 14'b1_1_111_0_1_111_1_010, 1'b1, 1'b0);
    check("R8 refused active", cmd_error, 1);
    check("R8 fields kept", seen_word(), model);
    repeat (TMRD) @(negedge clk);

    // R8: load straight after a load
    send(3'b000, 2'b00, 14'b0_1_001_0_0_110_0_010, 1'b1, 1'b0);
    model = 14'b0_1_001_0_0_110_0_010;
    send(3'b000, 2'b00, 14'b1_0_110_1_1_011_1_011, 1'b1, 1'b0);
    check("R8 refused reload", cmd_error, 1);
    check("R8 fields kept", seen_word(), model);
    repeat (TMRD) @(negedge clk);

    // R7: earliest accepted follow-up command is TMRD edges later
    send(3'b000, 2'b00, 14'b0_0_100_0_0_011_0_011, 1'b1, 1'b0);
    check("R7 ready low", cmd_ready, 0);
    for (int i = 1; i < TMRD - 1; i++) begin
      @(negedge clk);
      check("R7 ready low", cmd_ready, 0);
    end
    @(negedge clk);
    check("R7 ready high", cmd_ready, 1);
    send(3'b000, 2'b00, 14'b0_0_101_1_0_101_1_010, 1'b1, 1'b0);
    model = 14'b0_0_101_0_0_101_1_010;
    check("R7 follow-up taken", cmd_error, 0);
    check("R7 follow-up fields", seen_word(), 14'b0_0_101_1_0_101_1_010);
    @(negedge clk);
    check("R6 dll cleared", dll_reset, 0);
    repeat (TMRD) @(negedge clk);
    check("R11 hold", seen_word(), model);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule